// File: doc/BRIEF.md
# Serial Signature Analyzer

This block compacts a serial response stream into a short signature by dividing the stream, read as a polynomial over GF(2), by a fixed characteristic polynomial. The first bit accepted carries the highest power, and each later bit one power lower. After L accepted bits the N stages hold the remainder of that division. The stream of L bits is thus compacted into N bits.

A test controller pulses `clear` to zero the register, then feeds one response bit per cycle with `resp_valid` set. It may leave idle cycles between bits. It then pulses `done` while presenting the fault-free signature on `expected`. The `match` flag is latched at that strobe and stays put until the next clear or strobe. A faulty stream is flagged only when its remainder differs from the good one. A faulty stream whose remainder equals the good one passes unnoticed, which is aliasing.

The characteristic polynomial is a parameter, given by its coefficients below the leading term. A zero value turns the divider into a plain shift register.

Top module: `sig_analyzer`

## Requirements
- R1: A synchronous active-high `rst` sets `signature` to all-zero and `match` to 0 at the next rising edge.
- R2: On a cycle with `resp_valid` high and `clear` low, stage 0 loads `resp_bit` XOR (POLY[0] AND top stage). Each stage i>0 loads stage i-1 XOR (POLY[i] AND top stage). The top stage is `signature[N-1]`.
- R3: After L accepted bits from all-zero, `signature` bit i is the coefficient of X^i in M(X) mod P(X). The k-th accepted bit (k from 0) is the coefficient of X^(L-1-k) in M(X). P(X) is X^N plus the terms set in POLY. With N=3 and POLY=3'b011, the stream 1,0,1,1,0,0,0,1 leaves 3'b001.
- R4: A cycle with `resp_valid` low and `clear` low leaves `signature` unchanged, whatever `resp_bit` is.
- R5: `clear` has priority over `resp_valid`. A cycle with both high leaves `signature` all-zero.
- R6: On a cycle with `done` high and `clear` low, `match` becomes 1 if the `signature` present in that cycle equals `expected`, else 0. It is visible after the edge.
- R7: Between strobes, `match` holds its value while `expected`, `resp_bit` and `resp_valid` change.
- R8: With POLY all-zero, `signature` holds the last N accepted bits, with the most recent in bit 0.
- R9: A nonzero stream whose polynomial is a multiple of P(X) leaves the same all-zero signature as an empty stream. It therefore matches an expected value of 0.
- R10: `clear` (or `rst`) drops `match` to 0 at the next edge and has priority over `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Zero the signature and drop match |
| resp_bit | input | 1 | Serial response bit |
| resp_valid | input | 1 | Qualifies resp_bit for this cycle |
| done | input | 1 | Compare strobe |
| expected | input | WIDTH | Fault-free signature to compare against |
| signature | output | WIDTH | Current remainder, bit i = coefficient of X^i |
| match | output | 1 | Latched result of the last compare |

## Verification
The bench builds three copies that see one shared stream. The first uses the default 16-bit polynomial with coefficients 16'h1021 below X^16, which gives long random streams with real carry-over between stages. The second has N=3 and POLY=3'b011, which brings the worked eight-bit division and a short aliasing case within reach. The third has N=4 and POLY=0, which shows the plain shift-register case. All three are scored against a polynomial long-division model that works on the whole stream rather than stepping a register.

// File: rtl/sig_pkg.sv
package sig_pkg;

    typedef enum logic [1:0] {
        SA_HOLD  = 2'd0,
        SA_SHIFT = 2'd1,
        SA_CLEAR = 2'd2
    } sa_op_e;

    typedef enum logic [1:0] {
        CMP_KEEP = 2'd0,
        CMP_EVAL = 2'd1,
        CMP_DROP = 2'd2
    } cmp_op_e;

    typedef struct packed {
        sa_op_e  reg_op;
        cmp_op_e cmp_op;
    } sa_ctrl_t;

    function automatic sa_ctrl_t sa_decode(input logic rst, input logic clear,
                                           input logic valid, input logic done);
        sa_ctrl_t c;
        if (rst || clear) begin
            c.reg_op = SA_CLEAR;
            c.cmp_op = CMP_DROP;
        end else begin
            c.reg_op = valid ? SA_SHIFT : SA_HOLD;
            c.cmp_op = done  ? CMP_EVAL : CMP_KEEP;
        end
        return c;
    endfunction

endpackage

// File: rtl/sig_divider.sv
module sig_divider
    import sig_pkg::*;
#(
    parameter int unsigned       WIDTH = 16,
    parameter logic [WIDTH-1:0]  POLY  = 16'h1021
) (
    input  logic             clk,
    input  logic             rst,
    input  sa_op_e           op,
    input  logic             din,
    output logic [WIDTH-1:0] state
);

    localparam int unsigned TOP = WIDTH - 1;

    logic             fold;
    logic [WIDTH-1:0] nxt;

    assign fold = state[TOP];

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_stage
            logic shifted_in;
            if (i == 0) begin : g_low
                assign shifted_in = din;
            end else begin : g_up
                assign shifted_in = state[i-1];
            end
            if (POLY[i]) begin : g_tap
                assign nxt[i] = shifted_in ^ fold;
            end else begin : g_plain
                assign nxt[i] = shifted_in;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        case (op)
            SA_CLEAR: state <= '0;
            SA_SHIFT: state <= nxt;
            default:  state <= state;
        endcase
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (op == SA_CLEAR) |=> (state == '0)) else $error("clear"); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op == SA_HOLD) |=> $stable(state)) else $error("hold"); // R4

    AST_SHIFT_NOFOLD: assert property (@(posedge clk) disable iff (rst)
        (op == SA_SHIFT && !state[TOP]) |=>
            (state == {$past(state[TOP-1:0]), $past(din)})) else $error("shift"); // R2

endmodule

// File: rtl/sig_compare.sv
module sig_compare
    import sig_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  cmp_op_e          op,
    input  logic [WIDTH-1:0] sig,
    input  logic [WIDTH-1:0] golden,
    output logic             match
);

    logic equal;
    assign equal = (sig == golden);

    always_ff @(posedge clk) begin
        case (op)
            CMP_DROP: match <= 1'b0;
            CMP_EVAL: match <= equal;
            default:  match <= match;
        endcase
    end

    AST_MATCH_KEEP: assert property (@(posedge clk) disable iff (rst)
        (op == CMP_KEEP) |=> $stable(match)) else $error("keep"); // R7

    AST_MATCH_DROP: assert property (@(posedge clk) disable iff (rst)
        (op == CMP_DROP) |=> !match) else $error("drop"); // R10

endmodule

// File: rtl/sig_analyzer.sv
module sig_analyzer
    import sig_pkg::*;
#(
    parameter int unsigned       WIDTH = 16,
    parameter logic [WIDTH-1:0]  POLY  = 16'h1021
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             resp_bit,
    input  logic             resp_valid,
    input  logic             done,
    input  logic [WIDTH-1:0] expected,
    output logic [WIDTH-1:0] signature,
    output logic             match
);

    sa_ctrl_t ctrl;
    assign ctrl = sa_decode(rst, clear, resp_valid, done);

    sig_divider #(.WIDTH(WIDTH), .POLY(POLY)) u_div (
        .clk   (clk),
        .rst   (rst),
        .op    (ctrl.reg_op),
        .din   (resp_bit),
        .state (signature)
    );

    sig_compare #(.WIDTH(WIDTH)) u_cmp (
        .clk    (clk),
        .rst    (rst),
        .op     (ctrl.cmp_op),
        .sig    (signature),
        .golden (expected),
        .match  (match)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (signature == '0 && !match)) else $error("reset"); // R1

    AST_STROBE_RESULT: assert property (@(posedge clk) disable iff (rst)
        (done && !clear) |=> (match == ($past(signature) == $past(expected))))
        else $error("strobe"); // R6

endmodule

// File: tb/tb_sig_analyzer.sv
module tb_sig_analyzer;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst = 1'b1, clear = 1'b0, resp_bit = 1'b0, resp_valid = 1'b0, done = 1'b0;
    logic [15:0] e16 = '0;
    logic [2:0]  e3 = '0;
    logic [3:0]  e4 = '0;
    logic [15:0] sig16;
    logic [2:0]  sig3;
    logic [3:0]  sig4;
    logic        m16, m3, m4;

    sig_analyzer dut (.clk(clk), .rst(rst), .clear(clear), .resp_bit(resp_bit),
        .resp_valid(resp_valid), .done(done), .expected(e16), .signature(sig16), .match(m16));
    sig_analyzer #(.WIDTH(3), .POLY(3'b011)) u_ex (.clk(clk), .rst(rst), .clear(clear),
        .resp_bit(resp_bit), .resp_valid(resp_valid), .done(done), .expected(e3),
        .signature(sig3), .match(m3));
    sig_analyzer #(.WIDTH(4), .POLY(4'b0000)) u_sr (.clk(clk), .rst(rst), .clear(clear),
        .resp_bit(resp_bit), .resp_valid(resp_valid), .done(done), .expected(e4),
        .signature(sig4), .match(m4));

    int n_chk = 0, n_bad = 0;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic stream [0:99];

    function automatic logic [15:0] ref_rem(input int len, input int n, input logic [15:0] low);
        logic d [0:127];
        logic [15:0] r;
        for (int j = 0; j < 128; j++) d[j] = 1'b0;
        for (int k = 0; k < len; k++) d[len-1-k] = stream[k];
        for (int deg = len - 1; deg >= n; deg--) begin
            if (d[deg]) begin
                d[deg] = 1'b0;
                for (int i = 0; i < n; i++) d[deg-n+i] = d[deg-n+i] ^ low[i];
            end
        end
        r = '0;
        for (int i = 0; i < n; i++) r[i] = d[i];
        return r;
    endfunction

    typedef struct {
        string       tag;
        logic [15:0] s16; logic m16;
        logic [2:0]  s3;  logic m3;
        logic [3:0]  s4;  logic m4;
    } item_t;
    item_t q[$];

    // scoreboard monitor
    initial forever begin
        @(negedge clk);
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            chk({it.tag, " R3 sig16"}, sig16, it.s16);
            chk({it.tag, " R6 match16"}, {15'd0, m16}, {15'd0, it.m16});
            chk({it.tag, " R3 sig3"}, {13'd0, sig3}, {13'd0, it.s3});
            chk({it.tag, " R6 match3"}, {15'd0, m3}, {15'd0, it.m3});
            chk({it.tag, " R8 sig4"}, {12'd0, sig4}, {12'd0, it.s4});
            chk({it.tag, " R6 match4"}, {15'd0, m4}, {15'd0, it.m4});
        end
    end

    // driver: clear, feed stream with optional gaps, strobe done
    task automatic run(input string tag, input int len, input bit gaps,
                       input logic [15:0] x16, input logic [2:0] x3, input logic [3:0] x4);
        item_t it;
        @(negedge clk); clear = 1'b1;
        @(negedge clk); clear = 1'b0;
        for (int k = 0; k < len; k++) begin
            if (gaps && ($urandom % 3 == 0)) begin
                resp_valid = 1'b0; resp_bit = 1'($urandom);
                @(negedge clk);
            end
            resp_valid = 1'b1; resp_bit = stream[k];
            @(negedge clk);
        end
        resp_valid = 1'b0;
        e16 = x16; e3 = x3; e4 = x4; done = 1'b1;
        it.tag = tag;
        it.s16 = ref_rem(len, 16, 16'h1021);
        it.s3  = ref_rem(len, 3, 16'h0003)[2:0];
        it.s4  = ref_rem(len, 4, 16'h0000)[3:0];
        it.m16 = (it.s16 == x16);
        it.m3  = (it.s3 == x3);
        it.m4  = (it.s4 == x4);
        @(posedge clk);
        q.push_back(it);
        @(negedge clk); done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] r16;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset sig16", sig16, 16'h0);
        chk("R1 reset match16", {15'd0, m16}, 16'h0);
        chk("R1 reset sig3", {13'd0, sig3}, 16'h0);

        // R2 single steps on the 3-stage divider
        @(negedge clk); clear = 1'b1;
        @(negedge clk); clear = 1'b0; resp_valid = 1'b1; resp_bit = 1'b1;
        @(negedge clk); chk("R2 step1", {13'd0, sig3}, 16'h1);
        @(negedge clk); chk("R2 step2", {13'd0, sig3}, 16'h3);
        @(negedge clk); chk("R2 step3", {13'd0, sig3}, 16'h7);
        resp_bit = 1'b0;
        @(negedge clk); chk("R2 step4 fold", {13'd0, sig3}, 16'h5);
        resp_valid = 1'b0;

        // R3 worked example 10110001
        {stream[0], stream[1], stream[2], stream[3], stream[4], stream[5], stream[6], stream[7]} = 8'b10110001;
        r16 = ref_rem(8, 16, 16'h1021);
        run("example", 8, 1'b0, r16, 3'b001, ref_rem(8, 4, 16'h0)[3:0]);
        @(negedge clk);
        chk("R3 example remainder", {13'd0, sig3}, 16'h1);
        chk("R8 last four bits", {12'd0, sig4}, 16'h1);

        // R4 idle cycles with toggling data, R7 expected changes without strobe
        e3 = 3'b111; e16 = ~r16; e4 = 4'hF;
        for (int c = 0; c < 5; c++) begin
            resp_bit = c[0];
            @(negedge clk);
        end
        chk("R4 hold sig3", {13'd0, sig3}, 16'h1);
        chk("R4 hold sig16", sig16, r16);
        chk("R7 match3 kept", {15'd0, m3}, 16'h1);
        chk("R7 match16 kept", {15'd0, m16}, 16'h1);

        // R5 clear with valid, R10 clear drops match
        clear = 1'b1; resp_valid = 1'b1; resp_bit = 1'b1;
        @(negedge clk);
        clear = 1'b0; resp_valid = 1'b0;
        @(negedge clk);
        chk("R5 clear priority sig16", sig16, 16'h0);
        chk("R5 clear priority sig3", {13'd0, sig3}, 16'h0);
        chk("R10 match dropped", {15'd0, m3}, 16'h0);

        // R10 clear beats done
        e3 = 3'b000; clear = 1'b1; done = 1'b1;
        @(negedge clk); clear = 1'b0; done = 1'b0;
        chk("R10 clear over done", {15'd0, m3}, 16'h0);

        // R9 aliasing: 1011 = X^3+X+1 divides to zero, like the empty stream
        {stream[0], stream[1], stream[2], stream[3]} = 4'b1011;
        run("alias", 4, 1'b0, ref_rem(4, 16, 16'h1021), 3'b000, 4'hB);
        @(negedge clk);
        chk("R9 alias sig3 zero", {13'd0, sig3}, 16'h0);
        chk("R9 alias match3", {15'd0, m3}, 16'h1);
        run("empty", 0, 1'b0, 16'h0, 3'b000, 4'h0);

        // R8 shift register case directed
        {stream[0], stream[1], stream[2], stream[3], stream[4], stream[5]} = 6'b110100;
        run("shiftreg", 6, 1'b1, 16'h0, 3'b0, 4'b0100);
        @(negedge clk);
        chk("R8 shift register last bits", {12'd0, sig4}, 16'h4);

        // random streams, some with a corrupted expected word
        for (int t = 0; t < 40; t++) begin
            int len;
            logic [15:0] x16;
            logic [2:0]  x3;
            logic [3:0]  x4;
            len = 1 + int'($urandom % 64);
            for (int k = 0; k < len; k++) stream[k] = 1'($urandom);
            x16 = ref_rem(len, 16, 16'h1021);
            x3  = ref_rem(len, 3, 16'h0003)[2:0];
            x4  = ref_rem(len, 4, 16'h0)[3:0];
            if (t % 3 == 1) x16 = x16 ^ (16'h1 << (t % 16));
            if (t % 4 == 2) x3 = x3 ^ 3'b100;
            if (t % 5 == 3) x4 = x4 ^ 4'b0001;
            run("random", len, 1'b1, x16, x3, x4);
        end

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule